// File: doc/BRIEF.md
# Hybrid Shadow/Nested Page Walker

This block walks page tables to turn a guest virtual address into a host physical address. Each walk begins in a one-dimensional shadow table, which maps guest virtual pages straight to host physical pages. An entry can carry a switching bit. When it does, the walker leaves the shadow table and finishes in two-dimensional nested mode. In nested mode every guest table address is a guest physical address. That address is translated through the host (nested) table before the guest entry is read, and the final guest physical data page is translated the same way. Hot, stable regions of the address space are walked cheaply in the shadow table. Regions the guest rewrites often can be handed to nested mode from any level.

The walker holds one translation at a time. It latches the request and the three table roots when the request is accepted. It issues one memory read or write at a time over a valid/ready request port with a separate response strobe. It returns either the host physical address or a fault that names the table which faulted, together with the number of memory reads the walk used. As it goes it sets the accessed bit, and for store requests the dirty bit, in the entries it uses. It does this in the shadow, guest and nested tables alike, so no software has to reconcile them.

Top module: `hybrid_walker`

## Requirements
- R1: After reset, reqReady is 1, and respValid and memReqValid are 0.
- R2: A request is accepted only when reqReady is 1. reqReady drops in the cycle after acceptance and stays low until the response. reqValid raised during a walk has no effect on that walk's result.
- R3: Entries are 64 bits wide. Bit 0 is present, bit 5 is accessed, bit 6 is dirty, bit 9 is the switching bit, and bits [47:12] hold the next page number. The top level uses address bits [47:39], then [38:30] and [29:21], and the leaf uses [20:12]. An entry sits at its table page base plus index times 8.
- R4: A walk with no switching bit set reads four shadow entries starting from shadowRoot. It returns the leaf page concatenated with reqVa[11:0] and reports 4 accesses.
- R5: A shadow entry with the switching bit set, found at shadow read d (1 to 4), holds the guest physical page of the next guest table, or of the data page when d is 4. The remaining levels are walked nested, and the walk reports 24 - 4*d accesses. The switching bit in guest and nested entries has no effect.
- R6: With startNested set at request time, the walk is fully nested from guestRoot and reports 24 accesses.
- R7: Each guest physical page is translated through four nested reads from nestedRoot, using the same index fields taken from the guest physical address.
- R8: A non-present entry ends the walk with respFault 1 and respPa 0. respFaultSrc is 1 for shadow, 2 for guest and 3 for nested. respAccesses counts the reads done, including the faulting read, and the faulting entry is not written.
- R9: A present entry whose accessed bit is clear is written back with the bit set before the next read. An entry that already has its bits set is not written, and writes are not counted in respAccesses.
- R10: On a store request (reqWrite 1), the dirty bit is also set in the shadow leaf, the guest leaf and the nested leaf of the final data-page translation.
- R11: A memory request holds its valid, write flag, address and data stable until memReqReady, and only one memory operation is outstanding.
- R12: respValid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVa | input | 48 | Guest virtual address |
| reqWrite | input | 1 | Store access: set dirty bits in the leaves |
| shadowRoot | input | 36 | Shadow table root page (host physical) |
| guestRoot | input | 36 | Guest table root page (guest physical) |
| nestedRoot | input | 36 | Nested table root page (host physical) |
| startNested | input | 1 | Walk fully nested from the guest root |
| respValid | output | 1 | Result pulse |
| respFault | output | 1 | Walk ended on a non-present entry |
| respFaultSrc | output | 2 | 0 none, 1 shadow, 2 guest, 3 nested |
| respPa | output | 48 | Host physical address, 0 on fault |
| respAccesses | output | 5 | Memory reads the walk used |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 48 | Entry address |
| memReqWdata | output | 64 | Entry data for writes |
| memRspValid | input | 1 | Read data or write completion |
| memRspRdata | input | 64 | Read data |

## Verification
On every cycle, assertions check several rules. A stalled memory request keeps its address, data and direction. A busy walker refuses new work. The result strobe lasts one cycle. A successful walk always reports one of the access counts 4, 8, 12, 16, 20 or 24, and a fault always reports a zero address. Only the bench's scenarios can show the rest, because each needs a known table image. That covers where the switch happens and the access count it produces. It covers the host address that results, which table a planted hole is blamed on, and that the final memory image has exactly the accessed and dirty bits an independent walk model predicts.

// File: rtl/hwalk_pkg.sv
package hwalk_pkg;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_ACCESS  = 5;
  localparam int BIT_DIRTY   = 6;
  localparam int BIT_SWITCH  = 9;

  typedef enum logic [1:0] {
    FSRC_NONE   = 2'd0,
    FSRC_SHADOW = 2'd1,
    FSRC_GUEST  = 2'd2,
    FSRC_NESTED = 2'd3
  } faultSrcE;

  typedef enum logic [1:0] {
    PH_SHADOW = 2'd0,
    PH_NEST   = 2'd1,
    PH_GUEST  = 2'd2
  } phaseE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_DECIDE, ST_WR_REQ, ST_WR_WAIT, ST_RESP
  } walkStateE;

  typedef struct packed {
    logic start;
    logic capture;
    logic advance;
    logic faultLatch;
  } walkCtlT;

  typedef struct packed {
    logic present;
    logic needWrite;
    logic endsNow;
  } walkStatT;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import hwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  input  walkStatT stat,
  input  logic     memReqReady,
  input  logic     memRspValid,
  output logic     memReqValid,
  output logic     memReqWrite,
  output walkCtlT  ctl,
  output logic     respValid
);

  walkStateE stQ, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  always_comb begin
    stNext      = stQ;
    ctl         = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    reqReady    = (stQ == ST_IDLE);
    respValid   = (stQ == ST_RESP);
    case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.start = 1'b1;
          stNext    = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stNext = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memRspValid) begin
          ctl.capture = 1'b1;
          stNext      = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (!stat.present) begin
          ctl.faultLatch = 1'b1;
          stNext         = ST_RESP;
        end else if (stat.needWrite) begin
          stNext = ST_WR_REQ;
        end else begin
          ctl.advance = 1'b1;
          stNext      = stat.endsNow ? ST_RESP : ST_RD_REQ;
        end
      end
      ST_WR_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) stNext = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (memRspValid) begin
          ctl.advance = 1'b1;
          stNext      = stat.endsNow ? ST_RESP : ST_RD_REQ;
        end
      end
      ST_RESP: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  // R2: a busy walker does not take a second request
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R11: a stalled request keeps its valid and direction
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));

  // R12: result strobe is one cycle wide
  p_resp_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import hwalk_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_W    = 64,
  parameter int ADDR_W     = PAGE_SHIFT + LEVELS * IDX_W,
  parameter int CNT_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkCtlT               ctl,
  output walkStatT              stat,
  input  logic [ADDR_W-1:0]     reqVa,
  input  logic                  reqWrite,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] shadowRoot,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] guestRoot,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] nestedRoot,
  input  logic                  startNested,
  input  logic [ENTRY_W-1:0]    memRspRdata,
  output logic [ADDR_W-1:0]     rdAddr,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [ENTRY_W-1:0]    wrData,
  output logic [ADDR_W-1:0]     respPa,
  output logic                  respFault,
  output logic [1:0]            respFaultSrc,
  output logic [CNT_W-1:0]      respAccesses
);

  localparam int PG_W    = ADDR_W - PAGE_SHIFT;
  localparam int OFF_LOW = PAGE_SHIFT - IDX_W;
  localparam int LV_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int MAX_ACC = LEVELS * (LEVELS + 1) + LEVELS;
  localparam logic [LV_W-1:0] LAST_LV = LV_W'(LEVELS - 1);

  phaseE              phaseQ;
  logic [LV_W-1:0]    outLvlQ, nLvlQ;
  logic               nestFinalQ;
  logic [PG_W-1:0]    tblBaseQ, gpaPageQ, nestRootQ;
  logic [ADDR_W-1:0]  vaQ;
  logic               writeQ;
  logic [ENTRY_W-1:0] entryQ;
  logic [ADDR_W-1:0]  entryAddrQ;
  logic [CNT_W-1:0]   countQ;
  logic [ADDR_W-1:0]  resPaQ;
  logic               resFaultQ;
  faultSrcE           resSrcQ;

  logic [IDX_W-1:0] vaIdx  [LEVELS];
  logic [IDX_W-1:0] gpaIdx [LEVELS];

  // Index fields per level, top level first
  for (genvar gl = 0; gl < LEVELS; gl++) begin : g_idx
    assign vaIdx[gl]  = vaQ[ADDR_W-1-gl*IDX_W -: IDX_W];
    assign gpaIdx[gl] = gpaPageQ[PG_W-1-gl*IDX_W -: IDX_W];
  end

  logic [IDX_W-1:0]   selIdx;
  logic [PG_W-1:0]    entryPage;
  logic               lastOut, lastNest, dirtyElig, swBit;
  logic [ENTRY_W-1:0] updEntry;
  faultSrcE           curSrc;

  always_comb begin
    selIdx    = (phaseQ == PH_NEST) ? gpaIdx[nLvlQ] : vaIdx[outLvlQ];
    rdAddr    = {tblBaseQ, selIdx, {OFF_LOW{1'b0}}};
    entryPage = entryQ[ADDR_W-1:PAGE_SHIFT];
    swBit     = entryQ[BIT_SWITCH];
    lastOut   = (outLvlQ == LAST_LV);
    lastNest  = (nLvlQ == LAST_LV);
    dirtyElig = writeQ && (((phaseQ != PH_NEST) && lastOut) ||
                           ((phaseQ == PH_NEST) && nestFinalQ && lastNest));
    updEntry  = entryQ;
    updEntry[BIT_ACCESS] = 1'b1;
    if (dirtyElig) updEntry[BIT_DIRTY] = 1'b1;
    wrData    = updEntry;
    wrAddr    = entryAddrQ;

    stat.present   = entryQ[BIT_PRESENT];
    stat.needWrite = (updEntry != entryQ);
    case (phaseQ)
      PH_SHADOW: stat.endsNow = !swBit && lastOut;
      PH_NEST:   stat.endsNow = lastNest && nestFinalQ;
      default:   stat.endsNow = 1'b0;
    endcase
    case (phaseQ)
      PH_SHADOW: curSrc = FSRC_SHADOW;
      PH_GUEST:  curSrc = FSRC_GUEST;
      default:   curSrc = FSRC_NESTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ     <= PH_SHADOW;
      outLvlQ    <= '0;
      nLvlQ      <= '0;
      nestFinalQ <= 1'b0;
      tblBaseQ   <= '0;
      gpaPageQ   <= '0;
      nestRootQ  <= '0;
      vaQ        <= '0;
      writeQ     <= 1'b0;
      entryQ     <= '0;
      entryAddrQ <= '0;
      countQ     <= '0;
      resPaQ     <= '0;
      resFaultQ  <= 1'b0;
      resSrcQ    <= FSRC_NONE;
    end else begin
      if (ctl.start) begin
        vaQ        <= reqVa;
        writeQ     <= reqWrite;
        nestRootQ  <= nestedRoot;
        countQ     <= '0;
        outLvlQ    <= '0;
        nLvlQ      <= '0;
        nestFinalQ <= 1'b0;
        if (startNested) begin
          phaseQ   <= PH_NEST;
          gpaPageQ <= guestRoot;
          tblBaseQ <= nestedRoot;
        end else begin
          phaseQ   <= PH_SHADOW;
          tblBaseQ <= shadowRoot;
        end
      end
      if (ctl.capture) begin
        entryQ     <= memRspRdata;
        entryAddrQ <= rdAddr;
        countQ     <= countQ + 1'b1;
      end
      if (ctl.advance) begin
        case (phaseQ)
          PH_SHADOW: begin
            if (swBit) begin
              gpaPageQ <= entryPage;
              phaseQ   <= PH_NEST;
              tblBaseQ <= nestRootQ;
              nLvlQ    <= '0;
              if (lastOut) nestFinalQ <= 1'b1;
              else         outLvlQ    <= outLvlQ + 1'b1;
            end else if (!lastOut) begin
              tblBaseQ <= entryPage;
              outLvlQ  <= outLvlQ + 1'b1;
            end
          end
          PH_NEST: begin
            if (!lastNest) begin
              tblBaseQ <= entryPage;
              nLvlQ    <= nLvlQ + 1'b1;
            end else if (!nestFinalQ) begin
              phaseQ   <= PH_GUEST;
              tblBaseQ <= entryPage;
            end
          end
          PH_GUEST: begin
            gpaPageQ <= entryPage;
            phaseQ   <= PH_NEST;
            tblBaseQ <= nestRootQ;
            nLvlQ    <= '0;
            if (lastOut) nestFinalQ <= 1'b1;
            else         outLvlQ    <= outLvlQ + 1'b1;
          end
          default: ;
        endcase
        if (stat.endsNow) begin
          resPaQ    <= {entryPage, vaQ[PAGE_SHIFT-1:0]};
          resFaultQ <= 1'b0;
          resSrcQ   <= FSRC_NONE;
          countQ    <= countQ;
        end
      end
      if (ctl.faultLatch) begin
        resPaQ    <= '0;
        resFaultQ <= 1'b1;
        resSrcQ   <= curSrc;
      end
    end
  end

  assign respPa       = resPaQ;
  assign respFault    = resFaultQ;
  assign respFaultSrc = resSrcQ;
  assign respAccesses = countQ;

  // R7: the read counter never exceeds a fully nested walk
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(MAX_ACC));

  // R8: a faulted result carries no address
  p_fault_no_pa_r8: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respPa == '0);

endmodule

// File: rtl/hybrid_walker.sv
module hybrid_walker
  import hwalk_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_W    = 64,
  localparam int ADDR_W    = PAGE_SHIFT + LEVELS * IDX_W,
  localparam int PG_W      = ADDR_W - PAGE_SHIFT,
  localparam int MAX_ACC   = LEVELS * (LEVELS + 1) + LEVELS,
  localparam int CNT_W     = $clog2(MAX_ACC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqVa,
  input  logic               reqWrite,
  input  logic [PG_W-1:0]    shadowRoot,
  input  logic [PG_W-1:0]    guestRoot,
  input  logic [PG_W-1:0]    nestedRoot,
  input  logic               startNested,
  output logic               respValid,
  output logic               respFault,
  output logic [1:0]         respFaultSrc,
  output logic [ADDR_W-1:0]  respPa,
  output logic [CNT_W-1:0]   respAccesses,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [ENTRY_W-1:0] memReqWdata,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspRdata
);

  walkCtlT            ctl;
  walkStatT           stat;
  logic [ADDR_W-1:0]  rdAddr, wrAddr;
  logic [ENTRY_W-1:0] wrData;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .stat        (stat),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .ctl         (ctl),
    .respValid   (respValid)
  );

  walk_datapath #(
    .LEVELS     (LEVELS),
    .IDX_W      (IDX_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ENTRY_W    (ENTRY_W),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .reqVa        (reqVa),
    .reqWrite     (reqWrite),
    .shadowRoot   (shadowRoot),
    .guestRoot    (guestRoot),
    .nestedRoot   (nestedRoot),
    .startNested  (startNested),
    .memRspRdata  (memRspRdata),
    .rdAddr       (rdAddr),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .respPa       (respPa),
    .respFault    (respFault),
    .respFaultSrc (respFaultSrc),
    .respAccesses (respAccesses)
  );

  assign memReqAddr  = memReqWrite ? wrAddr : rdAddr;
  assign memReqWdata = wrData;

  // R11: address and data held while the request stalls
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqWdata));

  // R5: successful walks cost a whole multiple of four reads
  p_count_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respFault |->
      (respAccesses[1:0] == 2'b00) && (respAccesses >= CNT_W'(LEVELS)) &&
      (respAccesses <= CNT_W'(MAX_ACC)));

endmodule

// File: tb/hybrid_walker_tb.sv
module hybrid_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqWrite = 1'b0, startNested = 1'b0;
  logic [AW-1:0] reqVa = '0;
  logic [PW-1:0] shadowRoot = '0, guestRoot = '0, nestedRoot = '0;
  logic respValid, respFault;
  logic [1:0] respFaultSrc;
  logic [AW-1:0] respPa;
  logic [4:0] respAccesses;
  logic memReqValid, memReqWrite;
  logic memReqReady = 1'b0, memRspValid = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic [63:0] memReqWdata, memRspRdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqWrite(reqWrite), .shadowRoot(shadowRoot),
    .guestRoot(guestRoot), .nestedRoot(nestedRoot), .startNested(startNested),
    .respValid(respValid), .respFault(respFault), .respFaultSrc(respFaultSrc),
    .respPa(respPa), .respAccesses(respAccesses), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid), .memRspRdata(memRspRdata)
  );

  int nChecks = 0, nFails = 0;
  logic [63:0] mem    [logic [AW-1:0]];
  logic [63:0] expMem [logic [AW-1:0]];
  logic [AW-1:0] builtQ[$];
  logic [PW-1:0] hNext = 36'h100, gNext = 36'h40000;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: decides ready at the falling edge, answers later
  initial begin
    int timer = 0;
    logic [63:0] held = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memReqReady = 1'b0;
      if (!rstN) begin
        timer = 0;
      end else if (timer > 0) begin
        timer--;
        if (timer == 0) begin
          memRspValid = 1'b1;
          memRspRdata = held;
        end
      end else if (memReqValid && ($urandom % 4 != 0)) begin
        memReqReady = 1'b1;
        if (memReqWrite) mem[memReqAddr] = memReqWdata;
        else held = mem.exists(memReqAddr) ? mem[memReqAddr] : 64'd0;
        timer = 1 + ($urandom % 3);
      end
    end
  end

  // ---------------- independent walk model ----------------
  int mCnt; bit mFault; logic [1:0] mSrc; logic [AW-1:0] mPa; bit mWr;
  logic [PW-1:0] mNRoot;

  function automatic logic [8:0] idxOf(input logic [PW-1:0] pg, input int lv);
    return pg[PW-1-9*lv -: 9];
  endfunction

  function automatic logic [AW-1:0] entAddr(input logic [PW-1:0] pg, input logic [8:0] ix);
    return {pg, 12'h000} + {36'd0, ix, 3'b000};
  endfunction

  task automatic touch(input logic [AW-1:0] a, input bit dirt, output bit p,
                       output logic [63:0] e);
    e = expMem.exists(a) ? expMem[a] : 64'd0;
    mCnt++;
    p = e[0];
    if (p) begin
      logic [63:0] n = e;
      n[5] = 1'b1;
      if (dirt) n[6] = 1'b1;
      expMem[a] = n;
    end
  endtask

  task automatic mXlate(input logic [PW-1:0] gpg, input bit fin, output bit ok,
                        output logic [PW-1:0] hpg);
    logic [PW-1:0] base = mNRoot;
    ok = 1'b0; hpg = '0;
    for (int lv = 0; lv < 4; lv++) begin
      bit p; logic [63:0] e;
      touch(entAddr(base, idxOf(gpg, lv)), fin && mWr && lv == 3, p, e);
      if (!p) begin mFault = 1'b1; mSrc = 2'd3; return; end
      base = e[47:12];
    end
    ok = 1'b1; hpg = base;
  endtask

  task automatic runModel(input logic [AW-1:0] va, input bit wr, input logic [PW-1:0] sr,
                          input logic [PW-1:0] gr, input logic [PW-1:0] nr, input bit byp);
    logic [PW-1:0] vpg = va[47:12];
    logic [PW-1:0] gtbl = gr, base = sr, h;
    int startLv = 0;
    bit ok, p; logic [63:0] e;
    mCnt = 0; mFault = 0; mSrc = 0; mPa = '0; mWr = wr; mNRoot = nr;
    if (!byp) begin
      for (int lv = 0; lv < 4; lv++) begin
        touch(entAddr(base, idxOf(vpg, lv)), wr && lv == 3, p, e);
        if (!p) begin mFault = 1; mSrc = 2'd1; return; end
        if (e[9]) begin
          if (lv == 3) begin
            mXlate(e[47:12], 1'b1, ok, h);
            if (ok) mPa = {h, va[11:0]};
            return;
          end
          gtbl = e[47:12]; startLv = lv + 1;
          break;
        end
        if (lv == 3) begin mPa = {e[47:12], va[11:0]}; return; end
        base = e[47:12];
      end
    end
    for (int lv = startLv; lv < 4; lv++) begin
      mXlate(gtbl, 1'b0, ok, h);
      if (!ok) return;
      touch(entAddr(h, idxOf(vpg, lv)), wr && lv == 3, p, e);
      if (!p) begin mFault = 1; mSrc = 2'd2; return; end
      gtbl = e[47:12];
    end
    mXlate(gtbl, 1'b1, ok, h);
    if (ok) mPa = {h, va[11:0]};
  endtask

  // ---------------- table builder ----------------
  logic [PW-1:0] sRootB, gRootB, nRootB; bit bypB;

  function automatic logic [PW-1:0] allocH();
    hNext = hNext + 1;
    return hNext;
  endfunction

  function automatic logic [PW-1:0] allocG();
    gNext = gNext + 1 + ($urandom % 5);
    return gNext;
  endfunction

  task automatic setEntry(input logic [AW-1:0] a, input logic [PW-1:0] pg,
                          input bit sw, input bit junkSw);
    logic [63:0] e = {16'h0, pg, 12'h001};
    if ($urandom % 2) e[5] = 1'b1;
    if ($urandom % 3 == 0) e[6] = 1'b1;
    e[9] = sw | (junkSw && ($urandom % 2 == 1));
    mem[a] = e;
    builtQ.push_back(a);
  endtask

  task automatic mapNested(input logic [PW-1:0] gpg, input logic [PW-1:0] hpg);
    logic [PW-1:0] base = nRootB;
    for (int lv = 0; lv < 3; lv++) begin
      logic [AW-1:0] a = entAddr(base, idxOf(gpg, lv));
      if (mem.exists(a) && mem[a][0]) base = mem[a][47:12];
      else begin
        logic [PW-1:0] nb = allocH();
        setEntry(a, nb, 1'b0, 1'b1);
        base = nb;
      end
    end
    setEntry(entAddr(base, idxOf(gpg, 3)), hpg, 1'b0, 1'b1);
  endtask

  // d: 0 fully nested, 1..4 switch at that shadow read, 5 pure shadow
  task automatic build(input logic [AW-1:0] va, input int d);
    logic [PW-1:0] vpg = va[47:12];
    logic [PW-1:0] gT[5];
    logic [PW-1:0] base;
    mem.delete(); builtQ.delete();
    nRootB = allocH(); sRootB = allocH(); gRootB = allocG(); bypB = (d == 0);
    base = sRootB;
    if (d == 5) begin
      for (int lv = 0; lv < 4; lv++) begin
        logic [PW-1:0] nb = allocH();
        setEntry(entAddr(base, idxOf(vpg, lv)), nb, 1'b0, 1'b0);
        base = nb;
      end
      return;
    end
    for (int lv = 0; lv < 5; lv++) gT[lv] = allocG();
    if (d == 0) gRootB = gT[0];
    for (int lv = 0; lv < d; lv++) begin
      if (lv == d - 1) setEntry(entAddr(base, idxOf(vpg, lv)), gT[d], 1'b1, 1'b0);
      else begin
        logic [PW-1:0] nb = allocH();
        setEntry(entAddr(base, idxOf(vpg, lv)), nb, 1'b0, 1'b0);
        base = nb;
      end
    end
    for (int lv = d; lv < 4; lv++) begin
      logic [PW-1:0] h = allocH();
      mapNested(gT[lv], h);
      setEntry(entAddr(h, idxOf(vpg, lv)), gT[lv + 1], 1'b0, 1'b1);
    end
    mapNested(gT[4], allocH());
  endtask

  task automatic punchHole();
    int k = $urandom % builtQ.size();
    mem[builtQ[k]][0] = 1'b0;
  endtask

  // ---------------- one walk ----------------
  task automatic doWalk(input string req, input logic [AW-1:0] va, input bit wr,
                        input int expCnt);
    int waitC = 0;
    bit memOk = 1'b1;
    expMem = mem;
    runModel(va, wr, sRootB, gRootB, nRootB, bypB);
    @(negedge clk);
    reqVa = va; reqWrite = wr; shadowRoot = sRootB; guestRoot = gRootB;
    nestedRoot = nRootB; startNested = bypB; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2", "busy after accept", reqReady, 0);
    // stray request mid-walk must not disturb the result
    reqValid = 1'b1; reqVa = ~va; startNested = ~bypB;
    @(negedge clk);
    reqValid = 1'b0; reqVa = va; startNested = bypB;
    while (!respValid && waitC < 3000) begin @(negedge clk); waitC++; end
    check(respValid == 1'b1, req, "response seen", respValid, 1);
    check(respFault == mFault && respFaultSrc == mSrc, (mFault ? "R8" : req),
          "fault/source", {respFault, respFaultSrc}, {mFault, mSrc});
    check(respPa == mPa, req, "host address", respPa, mPa);
    check(int'(respAccesses) == mCnt, req, "access count", respAccesses, mCnt);
    if (expCnt >= 0)
      check(int'(respAccesses) == expCnt, req, "count formula", respAccesses, expCnt);
    if (mem.size() != expMem.size()) memOk = 1'b0;
    foreach (expMem[k]) if (!mem.exists(k) || mem[k] !== expMem[k]) memOk = 1'b0;
    check(memOk, (wr ? "R10" : "R9"), "accessed/dirty memory image", mem.size(), expMem.size());
    @(negedge clk);
    check(respValid == 1'b0, "R12", "single-cycle result", respValid, 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [AW-1:0] va;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && respValid == 1'b0 && memReqValid == 1'b0, "R1",
          "reset outputs", {reqReady, respValid, memReqValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);

    // directed: pure shadow and each switch depth (R3 field layout via fixed VA)
    va = 48'hA5C3_1E7F_9ABC;
    build(va, 5); doWalk("R4", va, 1'b0, 4);
    build(va, 4); doWalk("R5", va, 1'b0, 8);
    build(va, 3); doWalk("R5", va, 1'b1, 12);
    build(va, 2); doWalk("R5", va, 1'b0, 16);
    build(va, 1); doWalk("R7", va, 1'b1, 20);
    build(va, 0); doWalk("R6", va, 1'b1, 24);
    va = 48'hFFFF_FFFF_FFFF;
    build(va, 5); doWalk("R3", va, 1'b1, 4);
    va = 48'h0000_0000_0123;
    build(va, 2); doWalk("R3", va, 1'b0, 16);

    // directed faults
    build(va, 5); mem[builtQ[3]][0] = 1'b0; doWalk("R8", va, 1'b0, 4);
    build(va, 0); mem[builtQ[0]][0] = 1'b0; doWalk("R8", va, 1'b0, 1);
    build(va, 3); mem[builtQ[builtQ.size()-5]][0] = 1'b0; doWalk("R8", va, 1'b1, -1);

    // directed: bits already set, no writes expected
    build(va, 2);
    foreach (mem[k]) mem[k][6:5] = 2'b11;
    doWalk("R9", va, 1'b1, 16);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int d = $urandom % 6;
      va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      build(va, d);
      if ($urandom % 4 == 0) punchHole();
      doWalk("R5", va, ($urandom % 2 == 1), -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule